// File: doc/BRIEF.md
# Accumulator Window Extractor with Optional Saturation

This block pulls a 32-bit slice out of a 40-bit signed accumulator value, as a media datapath does when it narrows a wide multiply-accumulate result. A small signed offset taken from a cut operand decides where the slice sits. Zero or positive offsets move the slice towards the low end of the accumulator. This is a left shift of the accumulator that keeps the top half. Negative offsets shift the accumulator right arithmetically, so the slice fills with sign copies.

When saturation is enabled and the offset is zero or positive, a slice that would drop significant upper bits is replaced by the largest or smallest signed 32-bit value. The sign of the accumulator picks which one.

The extractor has a single register stage. An input marked valid produces a registered result and a valid flag on the next clock edge. The result register holds its value while no valid input arrives.

Top module: `acc_cut`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `result` is 0 until the first valid input is taken.
- R2: Only bits [5:0] of `cut_op` are used. They are read as a two's-complement offset c in the range -32..+31. Bits [7:6] have no effect on `result`.
- R3: For c >= 0 without saturation, `result` equals bits [63:32] of the 64-bit word {acc, 24 zero bits} shifted left by c. For example, an accumulator of 0x0012345678 with c = 0 gives 0x00123456, and with c = 8 gives 0x12345678.
- R4: For -31 <= c <= -1, `result` is the low 32 bits of {acc, 24 zero bits} shifted right arithmetically by (32 - c). Bit 39 of the accumulator is the sign.
- R5: For c = -32 (`cut_op[5:0]` = 6'b100000), `result` is 32 copies of accumulator bit 39: either 0x00000000 or 0xFFFFFFFF.
- R6: With `sat_en` = 1, c >= 0 and accumulator bits [39:39-c] not all equal, a non-negative accumulator gives `result` = 0x7FFFFFFF.
- R7: Under the same condition, a negative accumulator gives `result` = 0x80000000.
- R8: With `sat_en` = 1, c >= 0 and accumulator bits [39:39-c] all equal, `result` is the R3 value.
- R9: With `sat_en` = 1 and c < 0, `result` is the value R4 or R5 gives. No clamping is applied.
- R10: `result` and `out_valid` are updated on the clock edge that samples `in_valid` = 1, and `out_valid` then equals the `in_valid` sampled at each edge. While `in_valid` = 0, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The operands this cycle are to be taken |
| acc_in | input | 40 | Signed accumulator value |
| cut_op | input | 8 | Cut operand; the low 6 bits are the signed offset |
| sat_en | input | 1 | Enables clamping for offsets of zero or more |
| out_valid | output | 1 | A result was taken on the last edge |
| result | output | 32 | Registered 32-bit slice |

## Verification
Every result lands exactly one clock edge after its operands are presented. Each scenario task therefore drives the operands on a falling edge and reads `result` and `out_valid` on the next falling edge, half a period after the capturing edge. In the hold cases the task drops `in_valid` and changes the operands. One falling edge later it confirms that `out_valid` has cleared and that `result` still holds the earlier slice. Expected slices come from a 64-bit integer model of R3 to R9 in the bench.

// File: rtl/acc_cut_pkg.sv
package acc_cut_pkg;
  typedef enum logic [1:0] {
    CUT_LEFT  = 2'd0,
    CUT_RIGHT = 2'd1,
    CUT_FULL  = 2'd2
  } cut_kind_e;
endpackage

// File: rtl/acc_cut_decode.sv
module acc_cut_decode
  import acc_cut_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int CUT_W = 6,
  parameter int RES_W = 32,
  parameter int SH_W  = 7
) (
  input  logic [OP_W-1:0]  op,
  output cut_kind_e        kind,
  output logic [CUT_W-2:0] left_amt,
  output logic [SH_W-1:0]  right_amt
);
  logic [CUT_W-1:0] field;
  logic [CUT_W-1:0] mag;

  always_comb begin
    field     = op[CUT_W-1:0];
    mag       = CUT_W'(~field + 1'b1);
    left_amt  = field[CUT_W-2:0];
    right_amt = SH_W'(RES_W) + SH_W'(mag);
    if (!field[CUT_W-1])
      kind = CUT_LEFT;
    else if (field[CUT_W-2:0] == '0)
      kind = CUT_FULL;
    else
      kind = CUT_RIGHT;
  end
endmodule

// File: rtl/acc_cut_window.sv
module acc_cut_window
  import acc_cut_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int RES_W = 32,
  parameter int CUT_W = 6,
  parameter int SH_W  = 7
) (
  input  logic [ACC_W-1:0] acc,
  input  cut_kind_e        kind,
  input  logic [CUT_W-2:0] left_amt,
  input  logic [SH_W-1:0]  right_amt,
  output logic [RES_W-1:0] slice
);
  localparam int EXT_W = 2 * RES_W;
  localparam int ALIGN = EXT_W - ACC_W;

  logic signed [EXT_W-1:0] aligned;
  logic [EXT_W-1:0]        up_word;
  logic signed [EXT_W-1:0] dn_word;

  always_comb begin
    aligned = {acc, {ALIGN{1'b0}}};
    up_word = aligned << left_amt;
    dn_word = aligned >>> right_amt;
    unique case (kind)
      CUT_LEFT:  slice = up_word[EXT_W-1 -: RES_W];
      CUT_RIGHT: slice = dn_word[RES_W-1:0];
      default:   slice = {RES_W{acc[ACC_W-1]}};
    endcase
  end
endmodule

// File: rtl/acc_cut_satchk.sv
module acc_cut_satchk
  import acc_cut_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int RES_W = 32,
  parameter int CUT_W = 6,
  parameter int SH_W  = 7
) (
  input  logic [ACC_W-1:0] acc,
  input  cut_kind_e        kind,
  input  logic [CUT_W-2:0] left_amt,
  input  logic             sat_en,
  output logic             clamp,
  output logic [RES_W-1:0] clamp_val
);
  localparam int EXT_W = 2 * RES_W;
  localparam int ALIGN = EXT_W - ACC_W;

  logic signed [EXT_W-1:0] wide;
  logic signed [EXT_W-1:0] pushed;
  logic signed [EXT_W-1:0] pulled;
  logic [SH_W-1:0]         amt;

  always_comb begin
    wide      = {{ALIGN{acc[ACC_W-1]}}, acc};
    amt       = SH_W'(left_amt) + SH_W'(ALIGN);
    pushed    = wide <<< amt;
    pulled    = pushed >>> amt;
    clamp     = sat_en && (kind == CUT_LEFT) && (pulled != wide);
    clamp_val = acc[ACC_W-1] ? {1'b1, {(RES_W-1){1'b0}}}
                             : {1'b0, {(RES_W-1){1'b1}}};
  end
endmodule

// File: rtl/acc_cut.sv
module acc_cut
  import acc_cut_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int RES_W = 32,
  parameter int OP_W  = 8,
  parameter int CUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [OP_W-1:0]  cut_op,
  input  logic             sat_en,
  output logic             out_valid,
  output logic [RES_W-1:0] result
);
  localparam int SH_W = $clog2(2 * RES_W) + 1;

  cut_kind_e        kind;
  logic [CUT_W-2:0] left_amt;
  logic [SH_W-1:0]  right_amt;
  logic [RES_W-1:0] slice;
  logic             clamp;
  logic [RES_W-1:0] clamp_val;
  logic [RES_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  acc_cut_decode #(.OP_W(OP_W), .CUT_W(CUT_W), .RES_W(RES_W), .SH_W(SH_W)) u_dec (
    .op(cut_op), .kind(kind), .left_amt(left_amt), .right_amt(right_amt)
  );

  acc_cut_window #(.ACC_W(ACC_W), .RES_W(RES_W), .CUT_W(CUT_W), .SH_W(SH_W)) u_win (
    .acc(acc_in), .kind(kind), .left_amt(left_amt), .right_amt(right_amt),
    .slice(slice)
  );

  acc_cut_satchk #(.ACC_W(ACC_W), .RES_W(RES_W), .CUT_W(CUT_W), .SH_W(SH_W)) u_sat (
    .acc(acc_in), .kind(kind), .left_amt(left_amt), .sat_en(sat_en),
    .clamp(clamp), .clamp_val(clamp_val)
  );

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid)
      res_d = clamp ? clamp_val : slice;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R10
  AST_FULL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cut_op[CUT_W-1:0] == {1'b1, {(CUT_W-1){1'b0}}})
    |=> result == {RES_W{$past(acc_in[ACC_W-1])}}); // R5
  AST_RIGHT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cut_op[CUT_W-1])
    |=> result[RES_W-1] == $past(acc_in[ACC_W-1])); // R9
  AST_NO_WRONG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !cut_op[CUT_W-1] && !acc_in[ACC_W-1])
    |=> result != {1'b1, {(RES_W-1){1'b0}}}); // R6
endmodule

// File: tb/sim_acc_cut.sv
module sim_acc_cut;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [39:0] acc_in;
  logic [7:0]  cut_op;
  logic        sat_en;
  logic        out_valid;
  logic [31:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_cut u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
    .cut_op(cut_op), .sat_en(sat_en), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] model(input logic [39:0] a40, input logic [7:0] op,
                                        input bit sat);
    longint a, t;
    int c;
    logic [5:0] f;
    f = op[5:0];
    c = f[5] ? int'(f) - 64 : int'(f);
    a = longint'({{24{a40[39]}}, a40});
    if (c >= 0) begin
      t = a <<< (c + 24);
      if (sat && ((t >>> (c + 24)) != a))
        return a40[39] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return t[63:32];
    end
    if (c == -32) return {32{a40[39]}};
    t = (a <<< 24) >>> (32 - c);
    return t[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [39:0] a, input logic [7:0] op,
                         input bit sat);
    @(negedge clk);
    in_valid = 1'b1; acc_in = a; cut_op = op; sat_en = sat;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, result, model(a, op, sat));
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
  endtask

  task automatic t_left;
    run_one("R3 c0", 40'h00_1234_5678, 8'd0, 1'b0);
    check("R3 c0 literal", result, 32'h0012_3456);
    run_one("R3 c8", 40'h00_1234_5678, 8'd8, 1'b0);
    check("R3 c8 literal", result, 32'h1234_5678);
    run_one("R3 c31", 40'hA5_5A5A_C3C3, 8'd31, 1'b0);
    run_one("R3 c8 wrap", 40'h00_8000_0000, 8'd8, 1'b0);
    check("R3 wrap literal", result, 32'h8000_0000);
  endtask

  task automatic t_upper_bits;
    run_one("R2 base", 40'h3C_1234_5678, 8'h05, 1'b0);
    run_one("R2 high set", 40'h3C_1234_5678, 8'hC5, 1'b0);
    check("R2 literal", result, model(40'h3C_1234_5678, 8'h05, 1'b0));
  endtask

  task automatic t_right;
    run_one("R4 c-1", 40'h80_0000_1234, 8'h3F, 1'b0);
    run_one("R4 c-5", 40'h12_3456_789A, 8'h3B, 1'b0);
    run_one("R4 c-31", 40'hF0_0000_0000, 8'h21, 1'b0);
  endtask

  task automatic t_full;
    run_one("R5 pos", 40'h7F_FFFF_FFFF, 8'h20, 1'b0);
    check("R5 pos literal", result, 32'h0000_0000);
    run_one("R5 neg", 40'h80_0000_0000, 8'h20, 1'b1);
    check("R5 neg literal", result, 32'hFFFF_FFFF);
  endtask

  task automatic t_sat;
    run_one("R6 clamp hi", 40'h00_8000_0000, 8'd8, 1'b1);
    check("R6 literal", result, 32'h7FFF_FFFF);
    run_one("R7 clamp lo", 40'hFF_0000_0000, 8'd8, 1'b1);
    check("R7 literal", result, 32'h8000_0000);
    run_one("R8 fits c8", 40'h00_1234_5678, 8'd8, 1'b1);
    check("R8 literal", result, 32'h1234_5678);
    run_one("R8 c0 big", 40'h7F_FFFF_FFFF, 8'd0, 1'b1);
    check("R8 c0 literal", result, 32'h7FFF_FFFF);
    run_one("R9 neg cut", 40'h7F_FFFF_FFFF, 8'h3C, 1'b1);
    run_one("R9 full", 40'h7F_0000_0000, 8'h20, 1'b1);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    run_one("R10 load", 40'h01_0203_0405, 8'd4, 1'b0);
    keep = result;
    @(negedge clk);
    acc_in = 40'hFF_FFFF_FFFF; cut_op = 8'd0;
    @(negedge clk);
    check("R10 idle valid", {31'd0, out_valid}, 32'd0);
    check("R10 idle hold", result, keep);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; acc_in = '0; cut_op = '0; sat_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_left;
    t_upper_bits;
    t_right;
    t_full;
    t_sat;
    t_hold;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule